// File: doc/BRIEF.md
# Inverted-Compare 32-bit ALU

This is a purely combinational 32-bit arithmetic and logic unit for the execute stage of a small RISC pipeline. It takes two register operands, a 16-bit immediate, a 4-bit operation code and one extension-mode pin. It returns a 32-bit result and a flag that marks an all-zero result. The unit covers wrapping add and subtract, signed set-less-than with inverted polarity, a one-operand set-if-negative, load-upper-immediate, the four bitwise register operations, and immediate forms of add, AND and OR. It also forms load/store effective addresses as base plus offset.

The immediate is widened inside the block. The `imm_zext` pin selects zero extension when it is high and sign extension when it is low. The decoder drives it low for add-immediate and address generation, and high for AND-immediate and OR-immediate. All pins are plain combinational control and data. Results settle within the same cycle, so there is no handshake and no back-pressure: the surrounding pipeline register captures `result` and `zero` on its own clock edge.

Top module: `inv_cmp_alu`

## Requirements
- R1: With `alu_op`=0 the result is `src_a + src_b`, and with `alu_op`=1 it is `src_a - src_b`. Both wrap modulo 2^32 and signal nothing on overflow.
- R2: With `alu_op`=2 the operands are compared as signed two's-complement values. The result is 0 when `src_a` < `src_b` and 1 otherwise. The answer stays correct when the subtraction overflows.
- R3: With `alu_op`=3 the result is 0 when `src_a` bit 31 is set and 1 otherwise.
- R4: With `alu_op`=4 the result holds `imm16` in bits 31..16 and zeros in bits 15..0.
- R5: Codes 5, 6, 7 and 8 give the bitwise AND, OR, NOR and XOR of `src_a` and `src_b`.
- R6: Codes 9 (add-immediate), 10 (AND-immediate), 11 (OR-immediate) and 12 (address generation) combine `src_a` with the extended immediate in place of `src_b`. Code 12 is `src_a` plus the extended immediate. For all four codes, `src_b` has no effect on the result.
- R7: When `imm_zext`=0, the extended immediate is `imm16` sign-extended to 32 bits. When `imm_zext`=1, it is `imm16` zero-extended to 32 bits.
- R8: `zero` is high exactly when all 32 bits of `result` are 0.
- R9: Codes 13, 14 and 15 are reserved. For these codes the result is 0 and `zero` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_op | input | 4 | Operation code (see requirements) |
| src_a | input | 32 | First operand, also the base address |
| src_b | input | 32 | Second register operand |
| imm16 | input | 16 | Immediate field |
| imm_zext | input | 1 | 1 zero-extends the immediate, 0 sign-extends it |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The hardest case to reach is a signed compare where `src_a - src_b` overflows. In that case the sign bit of the difference gives the wrong answer, and the inverted output polarity must still follow the true ordering. The stimulus table sets this up directly with operand pairs at the extremes of the signed range, one pair for each sign mix. The unused `src_b` on immediate codes is loaded with a conspicuous nonzero pattern, so that any leak of it into the result shows up as a wrong value.

// File: rtl/inv_cmp_alu_pkg.sv
package inv_cmp_alu_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned IW = 16;
  localparam int unsigned OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_SLT  = 4'd2,
    OP_SLTZ = 4'd3,
    OP_LUI  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_NOR  = 4'd7,
    OP_XOR  = 4'd8,
    OP_ADDI = 4'd9,
    OP_ANDI = 4'd10,
    OP_ORI  = 4'd11,
    OP_ADDR = 4'd12
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_NOR = 2'd2,
    LG_XOR = 2'd3
  } logic_fn_e;
endpackage

// File: rtl/imm_widen.sv
module imm_widen #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 32
) (
  input  logic [IN_W-1:0]  imm_in,
  input  logic             zext,
  output logic [OUT_W-1:0] imm_out
);
  localparam int unsigned PAD = OUT_W - IN_W;
  logic pad_bit;

  // Fill bit: the immediate's sign bit, or zero in zero-extend mode.
  assign pad_bit = imm_in[IN_W-1] & ~zext;
  assign imm_out = {{PAD{pad_bit}}, imm_in};
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         negate_b,
  output logic [W-1:0] sum,
  output logic         signed_lt
);
  logic [W-1:0] b_eff;
  logic         ovf;

  // Subtraction is a plus inverted b plus one, so one adder serves both.
  assign b_eff = negate_b ? ~opb : opb;
  assign sum   = opa + b_eff + {{(W-1){1'b0}}, negate_b};

  // Signed less-than from the difference: flip the sign bit on overflow.
  assign ovf       = (opa[W-1] != opb[W-1]) && (sum[W-1] != opa[W-1]);
  assign signed_lt = sum[W-1] ^ ovf;
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import inv_cmp_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic_fn_e    fn,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (fn)
      LG_AND:  res = opa & opb;
      LG_OR:   res = opa | opb;
      LG_NOR:  res = ~(opa | opb);
      default: res = opa ^ opb;
    endcase
  end
endmodule

// File: rtl/inv_cmp_alu.sv
module inv_cmp_alu
  import inv_cmp_alu_pkg::*;
(
  input  logic [OPW-1:0] alu_op,
  input  logic [DW-1:0]  src_a,
  input  logic [DW-1:0]  src_b,
  input  logic [IW-1:0]  imm16,
  input  logic           imm_zext,
  output logic [DW-1:0]  result,
  output logic           zero
);
  localparam int unsigned LOW_W = DW - IW;

  logic [DW-1:0] imm_ext;
  logic          use_imm;
  logic          do_sub;
  logic [DW-1:0] opnd_b;
  logic [DW-1:0] add_out;
  logic          lt_s;
  logic [DW-1:0] logic_out;
  logic_fn_e     lfn;
  logic [DW-1:0] flag0;
  logic [DW-1:0] flag1;

  imm_widen #(.IN_W(IW), .OUT_W(DW)) u_widen (
    .imm_in  (imm16),
    .zext    (imm_zext),
    .imm_out (imm_ext)
  );

  always_comb begin
    use_imm = 1'b0;
    do_sub  = 1'b0;
    lfn     = LG_AND;
    unique case (alu_op)
      OP_SUB, OP_SLT: do_sub = 1'b1;
      OP_OR:   lfn = LG_OR;
      OP_NOR:  lfn = LG_NOR;
      OP_XOR:  lfn = LG_XOR;
      OP_ADDI, OP_ADDR, OP_ANDI: use_imm = 1'b1;
      OP_ORI:  begin use_imm = 1'b1; lfn = LG_OR; end
      default: ;
    endcase
  end

  assign opnd_b = use_imm ? imm_ext : src_b;

  alu_adder #(.W(DW)) u_add (
    .opa       (src_a),
    .opb       (opnd_b),
    .negate_b  (do_sub),
    .sum       (add_out),
    .signed_lt (lt_s)
  );

  alu_bitwise #(.W(DW)) u_logic (
    .opa (src_a),
    .opb (opnd_b),
    .fn  (lfn),
    .res (logic_out)
  );

  // Inverted-polarity flags: 0 when the condition holds, 1 when it fails.
  assign flag0 = {{(DW-1){1'b0}}, ~lt_s};
  assign flag1 = {{(DW-1){1'b0}}, ~src_a[DW-1]};

  always_comb begin
    unique case (alu_op)
      OP_ADD, OP_SUB, OP_ADDI, OP_ADDR:       result = add_out;
      OP_SLT:                                 result = flag0;
      OP_SLTZ:                                result = flag1;
      OP_LUI:                                 result = {imm16, {LOW_W{1'b0}}};
      OP_AND, OP_OR, OP_NOR, OP_XOR,
      OP_ANDI, OP_ORI:                        result = logic_out;
      default:                                result = '0;
    endcase
  end

  assign zero = ~|result;
endmodule

// File: rtl/inv_cmp_alu_chk.sv
module inv_cmp_alu_chk
  import inv_cmp_alu_pkg::*;
(
  input logic [OPW-1:0] alu_op,
  input logic [DW-1:0]  src_a,
  input logic [DW-1:0]  src_b,
  input logic [IW-1:0]  imm16,
  input logic           imm_zext,
  input logic [DW-1:0]  result,
  input logic           zero
);
  always_comb begin
    assert_zero_flag_R8: assert (zero == (result == '0));
    if (alu_op == OP_SLT)
      assert_slt_bool_R2: assert (result[DW-1:1] == '0);
    if (alu_op == OP_SLTZ)
      assert_sltz_sign_R3: assert (result[0] == ~src_a[DW-1]);
    if (alu_op == OP_LUI)
      assert_lui_low_R4: assert (result[DW-IW-1:0] == '0 && result[DW-1:DW-IW] == imm16);
    if (alu_op == OP_XOR && src_a == src_b)
      assert_xor_self_R5: assert (zero);
    if (alu_op == OP_ANDI && imm_zext)
      assert_andi_upper_R7: assert (result[DW-1:IW] == '0);
    if (alu_op == OP_ADD && src_b == '0)
      assert_add_ident_R1: assert (result == src_a);
    if (alu_op > OP_ADDR)
      assert_reserved_R9: assert (zero);
  end
endmodule

bind inv_cmp_alu inv_cmp_alu_chk u_chk (
  .alu_op   (alu_op),
  .src_a    (src_a),
  .src_b    (src_b),
  .imm16    (imm16),
  .imm_zext (imm_zext),
  .result   (result),
  .zero     (zero)
);

// File: tb/sim_inv_cmp_alu.sv
module sim_inv_cmp_alu;
  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] imm;
    logic        zx;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [0:NV-1] = '{
    '{4'd0,  32'h00000005, 32'h00000007, 16'h0000, 1'b0, 32'h0000000C, 8'd1},
    '{4'd0,  32'hFFFFFFFF, 32'h00000002, 16'h0000, 1'b0, 32'h00000001, 8'd1},
    '{4'd1,  32'h00000003, 32'h00000005, 16'h0000, 1'b0, 32'hFFFFFFFE, 8'd1},
    '{4'd1,  32'h00000009, 32'h00000009, 16'h0000, 1'b0, 32'h00000000, 8'd1},
    '{4'd2,  32'hFFFFFFFF, 32'h00000001, 16'h0000, 1'b0, 32'h00000000, 8'd2},
    '{4'd2,  32'h00000005, 32'h00000003, 16'h0000, 1'b0, 32'h00000001, 8'd2},
    '{4'd2,  32'h80000000, 32'h00000001, 16'h0000, 1'b0, 32'h00000000, 8'd2},
    '{4'd2,  32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0000, 1'b0, 32'h00000001, 8'd2},
    '{4'd2,  32'h00000004, 32'h00000004, 16'h0000, 1'b0, 32'h00000001, 8'd2},
    '{4'd3,  32'h80000001, 32'h00000000, 16'h0000, 1'b0, 32'h00000000, 8'd3},
    '{4'd3,  32'h00000000, 32'hFFFFFFFF, 16'h0000, 1'b0, 32'h00000001, 8'd3},
    '{4'd4,  32'hFFFFFFFF, 32'hFFFFFFFF, 16'hABCD, 1'b0, 32'hABCD0000, 8'd4},
    '{4'd5,  32'hF0F0FF00, 32'h0FF0F0F0, 16'h0000, 1'b0, 32'h00F0F000, 8'd5},
    '{4'd6,  32'hF0F0FF00, 32'h0FF0F0F0, 16'h0000, 1'b0, 32'hFFF0FFF0, 8'd5},
    '{4'd7,  32'hF0F0FF00, 32'h0FF0F0F0, 16'h0000, 1'b0, 32'h000F000F, 8'd5},
    '{4'd8,  32'hF0F0FF00, 32'h0FF0F0F0, 16'h0000, 1'b0, 32'hFF000FF0, 8'd5},
    '{4'd9,  32'h00000010, 32'hDEADBEEF, 16'hFFFE, 1'b0, 32'h0000000E, 8'd6},
    '{4'd9,  32'h00000010, 32'hDEADBEEF, 16'hFFFE, 1'b1, 32'h0001000E, 8'd7},
    '{4'd10, 32'hFFFFFFFF, 32'h12345678, 16'h8001, 1'b1, 32'h00008001, 8'd7},
    '{4'd10, 32'hFFFFFFFF, 32'h12345678, 16'h8001, 1'b0, 32'hFFFF8001, 8'd7},
    '{4'd11, 32'h12340000, 32'hCAFEF00D, 16'h8000, 1'b1, 32'h12348000, 8'd6},
    '{4'd12, 32'h00000100, 32'h55555555, 16'hFFFF, 1'b0, 32'h000000FF, 8'd6},
    '{4'd13, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 1'b1, 32'h00000000, 8'd9}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  alu_op = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [15:0] imm16 = '0;
  logic        imm_zext = 1'b0;
  logic [31:0] result;
  logic        zero;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  inv_cmp_alu u0 (
    .alu_op   (alu_op),
    .src_a    (src_a),
    .src_b    (src_b),
    .imm16    (imm16),
    .imm_zext (imm_zext),
    .result   (result),
    .zero     (zero)
  );

  task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic zx);
    @(negedge clk);
    alu_op = op; src_a = a; src_b = b; imm16 = im; imm_zext = zx;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] exp);
    n_chk++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s result actual=%h expected=%h", tag, result, exp);
    end
    n_chk++;
    if (zero !== (exp == 32'h0)) begin
      n_bad++;
      $display("FAIL R8 zero (%s) actual=%b expected=%b", tag, zero, exp == 32'h0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    check("R1 idle 0+0", 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].imm, VEC[i].zx);
      check($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].exp);
    end

    // R9: remaining reserved codes
    drive(4'd14, 32'h1, 32'h1, 16'h1, 1'b0); check("R9 op14", 32'h0);
    drive(4'd15, 32'h7, 32'h9, 16'h3, 1'b1); check("R9 op15", 32'h0);
    // R6: changing src_b under an immediate op leaves the result alone
    drive(4'd12, 32'h00000100, 32'h00000000, 16'h0004, 1'b0); check("R6 addr b=0", 32'h00000104);
    drive(4'd12, 32'h00000100, 32'hFFFFFFFF, 16'h0004, 1'b0); check("R6 addr b=ones", 32'h00000104);
    // R2: most negative versus most positive
    drive(4'd2, 32'h80000000, 32'h7FFFFFFF, 16'h0, 1'b0); check("R2 min<max", 32'h0);
    drive(4'd2, 32'h7FFFFFFF, 32'h80000000, 16'h0, 1'b0); check("R2 max>min", 32'h1);
    // R1: subtraction wraps through zero
    drive(4'd1, 32'h00000000, 32'h00000001, 16'h0, 1'b0); check("R1 0-1", 32'hFFFFFFFF);
    // R4 / R8: LUI of zero gives a zero result
    drive(4'd4, 32'hFFFFFFFF, 32'h0, 16'h0000, 1'b0); check("R4 lui 0", 32'h0);
    // R7: ORI with sign extension of a negative immediate
    drive(4'd11, 32'h00000000, 32'h0, 16'h8000, 1'b0); check("R7 ori sext", 32'hFFFF8000);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule